// File: doc/BRIEF.md
# Edge Port Interrupt Detector

This block watches up to seven external interrupt pins, numbered 1 to 7, and turns their activity into interrupt requests for a downstream interrupt controller. Pin 0 exists only as a reserved position: every register bit and mode field for it reads zero, and it never requests.

Each pin has a two-bit sensitivity code. The code selects an active-low level, a rising edge, a falling edge or both edges. Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the previous one. An edge sets a sticky per-pin flag. Software clears the flag by writing a 1 to its bit.

A direction register can turn a pin into a general output. Such a pin neither flags nor requests. An enable register gates the request lines but never the flags.

Software reaches four registers through a simple write strobe, a 2-bit address and a 16-bit data bus. Read data is combinational from the address.

Top module: `edge_port_irq`

## Requirements
- R1: After synchronous reset every register reads 0 and every request line is low. All pins are then inputs in level mode with requests disabled and flags clear.
- R2: The register at address 0 holds the sensitivity code of pin n in bits [2n+1:2n]. Code 00 means level (active low), 01 rising edge, 10 falling edge and 11 both edges. The direction register is at address 1, the enable register at address 2 and the flag register at address 3.
- R3: A pin change reaches the level request two clock edges after it is applied. An edge sets its flag on the third clock edge after the pin change.
- R4: In level mode, request n is high exactly while enable bit n is 1, direction bit n is 0 and the synchronized pin is low. The flag of a level pin never sets, and flag writes do not affect the request.
- R5: In an edge mode, the configured edge on an input pin sets flag n. Request n then equals flag n AND enable n AND input, and it stays high until software clears the flag.
- R6: Writing the flag register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Enable bit n at 0 holds request n low while flag n still latches. Setting the enable bit later raises the request at once from the stored flag.
- R8: A pin whose direction bit is 1 (output) sets no flag and raises no request.
- R9: Bit 0 of the direction, enable and flag registers and bits [1:0] of the mode register always read 0, even after writing ones to them.
- R10: When an edge event and a clearing write to the same flag bit meet on one clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 direction, 2 enable, 3 flag) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pin_i | input | 8 | External pins (bit 0 ignored) |
| irq_o | output | 7 | Request lines for pins 7 down to 1 |

## Verification
A software write to clear a flag and a fresh edge on the same pin can land on one clock edge. One rule must then win, and R10 says the edge wins. The bench provokes the collision by raising a pin, counting the two synchronizer edges, and presenting the clearing write on the exact edge at which the detector reports the event. A reference model that updates on every clock judges the outcome: the flag must read back set and the request must stay high. The same per-cycle comparison also judges the milder overlaps, such as a level-pin flag write or an enable change while a flag is pending.

// File: rtl/edge_port_pkg.sv
package edge_port_pkg;

    localparam int EP_PINS   = 8;
    localparam int EP_DATA_W = 2 * EP_PINS;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        RA_MODE = 2'd0,
        RA_DIR  = 2'd1,
        RA_EN   = 2'd2,
        RA_FLAG = 2'd3
    } reg_addr_e;

    // Does the pair (previous, current) match the selected sensitivity?
    function automatic logic edge_hit(input sense_e s, input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = ~prev & cur;
        fall = prev & ~cur;
        case (s)
            SENSE_RISE: edge_hit = rise;
            SENSE_FALL: edge_hit = fall;
            SENSE_BOTH: edge_hit = rise | fall;
            default:    edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ep_sync.sv
module ep_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Idle state of the pins is high; reset the stages there so that
    // leaving reset does not fabricate a rising edge.
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/ep_detect.sv
module ep_detect
    import edge_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   sync_i,
    input  logic [2*PINS-1:0] mode_i,
    input  logic [PINS-1:0]   dir_i,
    output logic [PINS-1:0]   evt_o
);
    localparam logic [PINS-1:0] PIN_MASK = {{(PINS-1){1'b1}}, 1'b0};

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= sync_i;
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign hit[n] = edge_hit(sense_e'(mode_i[2*n +: 2]), prev_q[n], sync_i[n]);
    end

    // Output pins and the reserved position never report.
    assign evt_o = hit & ~dir_i & PIN_MASK;
endmodule

// File: rtl/ep_regs.sv
module ep_regs
    import edge_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [2*PINS-1:0] wdata_i,
    input  logic [PINS-1:0]   evt_i,
    output logic [2*PINS-1:0] rdata_o,
    output logic [2*PINS-1:0] mode_o,
    output logic [PINS-1:0]   dir_o,
    output logic [PINS-1:0]   en_o,
    output logic [PINS-1:0]   flag_o
);
    localparam int DW = 2 * PINS;
    localparam logic [PINS-1:0] PIN_MASK  = {{(PINS-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0]   MODE_MASK = {{(DW-2){1'b1}}, 2'b00};

    logic [DW-1:0]   mode_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] en_q;
    logic [PINS-1:0] flag_q;
    logic [PINS-1:0] clr;
    reg_addr_e       ra;

    assign ra  = reg_addr_e'(addr_i);
    assign clr = (wr_i && ra == RA_FLAG) ? wdata_i[PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (wr_i && ra == RA_MODE) mode_q <= wdata_i & MODE_MASK;
            if (wr_i && ra == RA_DIR)  dir_q  <= wdata_i[PINS-1:0] & PIN_MASK;
            if (wr_i && ra == RA_EN)   en_q   <= wdata_i[PINS-1:0] & PIN_MASK;
            // A new event wins over a simultaneous clear.
            flag_q <= ((flag_q & ~clr) | evt_i) & PIN_MASK;
        end
    end

    always_comb begin
        case (ra)
            RA_MODE: rdata_o = mode_q;
            RA_DIR:  rdata_o = {{(DW-PINS){1'b0}}, dir_q};
            RA_EN:   rdata_o = {{(DW-PINS){1'b0}}, en_q};
            default: rdata_o = {{(DW-PINS){1'b0}}, flag_q};
        endcase
    end

    assign mode_o = mode_q;
    assign dir_o  = dir_q;
    assign en_o   = en_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/edge_port_irq.sv
module edge_port_irq
    import edge_port_pkg::*;
#(
    parameter int PINS = EP_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [2*PINS-1:0] reg_wdata,
    output logic [2*PINS-1:0] reg_rdata,
    input  logic [PINS-1:0]   pin_i,
    output logic [PINS-1:1]   irq_o
);
    logic [PINS-1:0]   pin_sync;
    logic [PINS-1:0]   evt;
    logic [2*PINS-1:0] mode_q;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   en_q;
    logic [PINS-1:0]   flag_q;

    ep_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    ep_detect #(.PINS(PINS)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .sync_i (pin_sync),
        .mode_i (mode_q),
        .dir_i  (dir_q),
        .evt_o  (evt)
    );

    ep_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .evt_i   (evt),
        .rdata_o (reg_rdata),
        .mode_o  (mode_q),
        .dir_o   (dir_q),
        .en_o    (en_q),
        .flag_o  (flag_q)
    );

    for (genvar n = 1; n < PINS; n++) begin : g_req
        sense_e s;
        assign s = sense_e'(mode_q[2*n +: 2]);
        assign irq_o[n] = en_q[n] & ~dir_q[n] &
                          ((s == SENSE_LEVEL) ? ~pin_sync[n] : flag_q[n]);
    end
endmodule

// File: rtl/ep_checker.sv
module ep_checker #(
    parameter int PINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [2*PINS-1:0] reg_wdata,
    input logic [PINS-1:0]   evt,
    input logic [PINS-1:0]   flag_q,
    input logic [PINS-1:0]   en_q,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:1]   irq_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq_o == '0 && flag_q == '0));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q[0] == 1'b0 && en_q[0] == 1'b0 && dir_q[0] == 1'b0));

    for (genvar n = 1; n < PINS; n++) begin : g_chk
        // R10
        event_sets_chk: assert property (@(posedge clk) disable iff (rst)
            evt[n] |=> flag_q[n]);

        // R6
        clear_one_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == 2'd3 && reg_wdata[n] && !evt[n]) |=> !flag_q[n]);

        // R5
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_q[n] && !(reg_wr && reg_addr == 2'd3 && reg_wdata[n])) |=> flag_q[n]);

        // R7
        enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
            irq_o[n] |-> en_q[n]);

        // R8
        output_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            dir_q[n] |-> (!irq_o[n] && !evt[n]));
    end
endmodule

bind edge_port_irq ep_checker #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt       (evt),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .dir_q     (dir_q),
    .irq_o     (irq_o)
);

// File: tb/edge_port_irq_tb.sv
`timescale 1ns/1ps
module edge_port_irq_tb;
    localparam int PINS = 8;
    localparam int DW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [PINS-1:0] pin_i = '1;
    logic [PINS-1:1] irq_o;

    always #2.5 clk = ~clk;

    edge_port_irq #(.PINS(PINS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_i     (pin_i),
        .irq_o     (irq_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit armed    = 0;
    bit done     = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [DW-1:0]   m_mode = '0;
    logic [PINS-1:0] m_dir = '0, m_en = '0, m_flag = '0;
    logic [PINS-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1;

    always @(posedge clk) begin : model
        logic [PINS-1:0] hit;
        logic [PINS-1:0] clr;
        if (rst) begin
            m_mode = '0; m_dir = '0; m_en = '0; m_flag = '0;
            m_s1 = '1; m_s2 = '1; m_prev = '1;
        end else begin
            hit = '0;
            for (int n = 1; n < PINS; n++) begin
                case (m_mode[2*n +: 2])
                    2'b01: hit[n] = !m_prev[n] && m_s2[n];
                    2'b10: hit[n] = m_prev[n] && !m_s2[n];
                    2'b11: hit[n] = m_prev[n] != m_s2[n];
                    default: hit[n] = 1'b0;
                endcase
                if (m_dir[n]) hit[n] = 1'b0;
            end
            clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata[PINS-1:0] : '0;
            m_flag = ((m_flag & ~clr) | hit) & 8'hFE;
            if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata & 16'hFFFC;
            if (reg_wr && reg_addr == 2'd1) m_dir  = reg_wdata[7:0] & 8'hFE;
            if (reg_wr && reg_addr == 2'd2) m_en   = reg_wdata[7:0] & 8'hFE;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
        end
        armed <= 1'b1;
    end

    function automatic logic exp_irq(input int n);
        if (m_mode[2*n +: 2] == 2'b00) return m_en[n] && !m_dir[n] && !m_s2[n];
        return m_flag[n] && m_en[n] && !m_dir[n];
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_mode;
            2'd1: return {8'h00, m_dir};
            2'd2: return {8'h00, m_en};
            default: return {8'h00, m_flag};
        endcase
    endfunction

    // Per-cycle comparison: R4 for level pins, R5 for edge pins, R2 for reads
    always @(negedge clk) begin
        if (armed && !rst && !done) begin
            for (int n = 1; n < PINS; n++) begin
                if (m_mode[2*n +: 2] == 2'b00) chk($sformatf("R4 irq%0d", n), {15'd0, irq_o[n]}, {15'd0, exp_irq(n)});
                else                           chk($sformatf("R5 irq%0d", n), {15'd0, irq_o[n]}, {15'd0, exp_irq(n)});
            end
            chk("R2 readback", reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic post_edge();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        post_edge();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        post_edge();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
        post_edge();
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(input int n, input logic exp, input string tag);
        @(negedge clk);
        chk(tag, {15'd0, irq_o[n]}, {15'd0, exp});
    endtask

    task automatic settle();
        repeat (5) post_edge();
    endtask

    initial begin
        fork
            begin
                #(200000 * 5);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(2'd0, 16'h0000, "R1 mode");
        rd(2'd1, 16'h0000, "R1 dir");
        rd(2'd2, 16'h0000, "R1 en");
        rd(2'd3, 16'h0000, "R1 flag");
        @(negedge clk); chk("R1 irq", {9'd0, irq_o}, 16'h0000);

        // R2/R9: pin7 fall, pin6 level, pin5 rise, pin4 both, pin3 fall, pin2 rise, pin1 level
        wr(2'd0, 16'h8793);
        rd(2'd0, 16'h8790, "R9 mode field 0");
        wr(2'd1, 16'h0001);
        rd(2'd1, 16'h0000, "R9 dir bit0");
        wr(2'd2, 16'h00FF);
        rd(2'd2, 16'h00FE, "R9 en bit0");

        // R3/R4: level pin 1 through the synchronizer
        post_edge(); pin_i[1] = 1'b0;
        irq_is(1, 1'b0, "R3 level not yet");
        irq_is(1, 1'b0, "R3 level after one edge");
        irq_is(1, 1'b1, "R3 level after two edges");
        wr(2'd3, 16'h0002);
        irq_is(1, 1'b1, "R4 flag write no effect");
        rd(2'd3, 16'h0000, "R4 level never flags");
        post_edge(); pin_i[1] = 1'b1;
        settle();
        irq_is(1, 1'b0, "R4 level released");

        // R2/R5: rising pin 2, falling edge ignored
        post_edge(); pin_i[2] = 1'b0;
        settle();
        rd(2'd3, 16'h0000, "R2 rise ignores fall");
        post_edge(); pin_i[2] = 1'b1;
        irq_is(2, 1'b0, "R3 edge cycle 0");
        irq_is(2, 1'b0, "R3 edge cycle 1");
        irq_is(2, 1'b0, "R3 edge cycle 2");
        irq_is(2, 1'b1, "R3 edge flagged on third edge");
        settle();
        irq_is(2, 1'b1, "R5 request held");

        // R6: write-one-to-clear
        wr(2'd3, 16'h0000);
        rd(2'd3, 16'h0004, "R6 zero keeps flag");
        wr(2'd3, 16'h0004);
        rd(2'd3, 16'h0000, "R6 one clears flag");
        irq_is(2, 1'b0, "R6 request drops");

        // R2: both edges on pin 4, falling on pin 3
        post_edge(); pin_i[4] = 1'b0; pin_i[3] = 1'b0;
        settle();
        rd(2'd3, 16'h0018, "R2 both and fall flag");
        wr(2'd3, 16'h0018);
        post_edge(); pin_i[4] = 1'b1; pin_i[3] = 1'b1;
        settle();
        rd(2'd3, 16'h0010, "R2 both flags rise, fall does not");
        wr(2'd3, 16'h0010);

        // R7: enable gates request, flag still latches
        wr(2'd2, 16'h00DE);
        post_edge(); pin_i[5] = 1'b0;
        settle();
        post_edge(); pin_i[5] = 1'b1;
        settle();
        rd(2'd3, 16'h0020, "R7 flag latches while disabled");
        irq_is(5, 1'b0, "R7 request held low");
        wr(2'd2, 16'h00FE);
        irq_is(5, 1'b1, "R7 request from stored flag");
        wr(2'd3, 16'h0020);

        // R8: output pin is ignored
        wr(2'd1, 16'h0080);
        post_edge(); pin_i[7] = 1'b0;
        settle();
        rd(2'd3, 16'h0000, "R8 output pin no flag");
        irq_is(7, 1'b0, "R8 output pin no request");
        post_edge(); pin_i[7] = 1'b1;
        settle();
        wr(2'd1, 16'h0000);

        // R10: edge and clear on the same clock edge
        post_edge(); pin_i[2] = 1'b0;
        settle();
        post_edge(); pin_i[2] = 1'b1;
        settle();
        rd(2'd3, 16'h0004, "R10 flag preset");
        post_edge(); pin_i[2] = 1'b0;
        settle();
        post_edge(); pin_i[2] = 1'b1;
        post_edge();
        post_edge();
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0004;
        post_edge();
        reg_wr = 1'b0;
        rd(2'd3, 16'h0004, "R10 edge beats clear");
        irq_is(2, 1'b1, "R10 request stays high");

        settle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule